// File: doc/BRIEF.md
# Time-Multiplexed Event Distributor

This block sits on one region-input link of a time-multiplexed trigger. Each bunch crossing the link may carry one word of tower data. A word holds several towers side by side, one lane per φ position. The words of one event come in tagged with their |η| slot, and an event-start strobe opens each event. Once SPAN words of an event have arrived, the block plays the whole event out to a single processing node over exactly SPAN consecutive crossings. Slots are played in order of increasing |η|, and each φ lane keeps its bit field. The next event goes to the next node, rotating through NODES nodes.

Storage is double-banked. One event is gathered in one bank while the previous event is replayed from the other. Events can therefore arrive back to back with no gap, and the node streams stay seamless. The output schedule is fixed by arrival time alone. No node can stall a stream, so there is no ready signal on either side: the input is a valid-qualified word stream and each node output is a valid-qualified word stream with a first-word flag. Nodes must accept one word per crossing while their valid is high. Because NODES is at least SPAN, a node has finished its previous event before its turn returns.

Top module: `tmx_event_distributor`

## Requirements
- R1: During reset and after it, until the first event completes, every node_valid and node_first bit is 0 and every node_data word is 0.
- R2: An event is opened by a cycle with in_valid=1 and in_start=1, which counts as its first word. It is complete on its SPAN-th accepted word. Idle cycles (in_valid=0) may occur inside an event and do not count.
- R3: Replay starts in the cycle after the completing word is sampled. It lasts exactly SPAN consecutive cycles on one node, and node_first is 1 only in the first of them.
- R4: The replay presents slot 0, 1, …, SPAN-1 in that order, whatever order the slots arrived in. The slot of a word is in_slot. When a slot is written twice, the later word wins.
- R5: Lane j of a tower word (bits j*TOWER_W to j*TOWER_W+TOWER_W-1) appears unchanged in the same bit positions of node_data.
- R6: The first event after reset goes to node 0. Each later event goes to the node after the previous one, and node NODES-1 is followed by node 0.
- R7: At most one node_valid bit is 1 in any cycle. Every node whose valid is 0 shows node_first=0 and node_data=0.
- R8: A slot that received no word during the event is replayed as an all-zero word.
- R9: An in_start with in_valid=1 before the current event is complete discards the partial event and begins a new one. A word with in_valid=1 and in_start=0 outside an event, or an in_start with in_valid=0, is ignored.
- R10: An event may begin in the cycle right after the previous one completes. Its replay then follows the previous replay with no idle cycle.
- R11: NODES must be at least SPAN, and SPAN at least 2. This is checked when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word present this crossing |
| in_start | input | 1 | Word opens a new event (qualified by in_valid) |
| in_slot | input | log2(SPAN) | |η| slot of the input word |
| in_word | input | LANES*TOWER_W | Towers of the word, lane j = φ position j |
| node_valid | output | NODES | Per-node word valid |
| node_first | output | NODES | Per-node first word of an event |
| node_data | output | NODES x LANES*TOWER_W | Per-node tower word, zero when not valid |

## Verification
Assertions check every cycle that at most one node is driven and that idle nodes stay silent. They also check that a replay holds one node for SPAN cycles without overlap, that consecutive events step to the next node, and that two completions are never adjacent. The bench's scenarios are what show the data path. These include reordering of reversed and permuted slots, a later write to a slot winning over an earlier one, zero fill of missing slots, and lane placement. The scenarios also show that partial events are dropped, stray words are ignored, and exact replay timing holds across back-to-back events, with the node pointer wrapping.

// File: rtl/tmx_pkg.sv
package tmx_pkg;

  // Index width for a count of n items, never below one bit.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  typedef enum logic {
    RP_IDLE = 1'b0,
    RP_RUN  = 1'b1
  } rp_state_e;

endpackage

// File: rtl/tmx_capture.sv
module tmx_capture #(
  parameter int SPAN   = 4,
  parameter int SLOT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_start,
  output logic accept,
  output logic open_evt,
  output logic done
);

  logic              collecting;
  logic [SLOT_W-1:0] taken;
  logic              last;

  assign open_evt = in_valid && in_start;
  assign accept   = in_valid && (in_start || collecting);
  assign last     = in_start ? (SPAN == 1) : (taken == SLOT_W'(SPAN - 1));
  assign done     = accept && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collecting <= 1'b0;
      taken      <= '0;
    end else if (open_evt) begin
      collecting <= 1'b1;
      taken      <= SLOT_W'(1);
    end else if (accept) begin
      if (last) begin
        collecting <= 1'b0;
        taken      <= '0;
      end else begin
        taken <= taken + SLOT_W'(1);
      end
    end
  end

  // R2: completions are at least SPAN (>= 2) words apart
  a_r2_done_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a stray word outside an event does not open one
  a_r9_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_start && !collecting) |=> !collecting);

endmodule

// File: rtl/tmx_bank_store.sv
module tmx_bank_store #(
  parameter int SPAN   = 4,
  parameter int WORD_W = 32,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_open,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              swap,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [WORD_W-1:0] rd_word
);

  logic                  wr_bank;
  logic                  rd_bank;
  logic                  slot_ok;
  logic [WORD_W-1:0]     mem [2][SPAN];
  logic [1:0][SPAN-1:0]  filled;

  assign rd_bank = ~wr_bank;
  assign slot_ok = (int'(wr_slot) < SPAN);

  always_ff @(posedge clk) begin
    if (!rst_n) wr_bank <= 1'b0;
    else if (swap) wr_bank <= ~wr_bank;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (wr_en && slot_ok && (wr_bank == 1'(b)))
        mem[b][wr_slot] <= wr_word;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        filled[b] <= '0;
      end else if (wr_bank == 1'(b)) begin
        if (wr_open) begin
          filled[b] <= slot_ok ? (SPAN'(1) << wr_slot) : '0;
        end else if (wr_en && slot_ok) begin
          filled[b][wr_slot] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (int'(rd_slot) < SPAN && filled[rd_bank][rd_slot])
      rd_word = mem[rd_bank][rd_slot];
  end

endmodule

// File: rtl/tmx_replay.sv
module tmx_replay
  import tmx_pkg::*;
#(
  parameter int SPAN   = 4,
  parameter int NODES  = 5,
  parameter int SLOT_W = 2,
  parameter int NODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  output logic              run,
  output logic              first,
  output logic [SLOT_W-1:0] rd_slot,
  output logic [NODE_W-1:0] node_sel
);

  rp_state_e         state;
  logic [SLOT_W-1:0] idx;
  logic [NODE_W-1:0] ptr;
  logic              at_end;

  assign at_end = (idx == SLOT_W'(SPAN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RP_IDLE;
      idx      <= '0;
      node_sel <= '0;
      ptr      <= '0;
    end else if (launch) begin
      state    <= RP_RUN;
      idx      <= '0;
      node_sel <= ptr;
      ptr      <= (ptr == NODE_W'(NODES - 1)) ? '0 : ptr + NODE_W'(1);
    end else if (state == RP_RUN) begin
      if (at_end) begin
        state <= RP_IDLE;
        idx   <= '0;
      end else begin
        idx <= idx + SLOT_W'(1);
      end
    end
  end

  assign run     = (state == RP_RUN);
  assign first   = run && (idx == '0);
  assign rd_slot = idx;

  // R3: a replay keeps its node and advances one slot per cycle
  a_r3_span_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_end && !launch) |=> run && $stable(node_sel) && (idx == $past(idx) + SLOT_W'(1)));

  // R10: a new replay only starts as the previous one ends
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (!run || at_end));

  // R6: back-to-back events move to the following node
  a_r6_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && run) |=> node_sel == (($past(node_sel) == NODE_W'(NODES - 1)) ? '0 : $past(node_sel) + NODE_W'(1)));

  a_r6_node_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (int'(node_sel) < NODES));

endmodule

// File: rtl/tmx_fanout.sv
module tmx_fanout #(
  parameter int NODES  = 5,
  parameter int WORD_W = 32,
  parameter int NODE_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run,
  input  logic                          first,
  input  logic [NODE_W-1:0]             node_sel,
  input  logic [WORD_W-1:0]             word,
  output logic [NODES-1:0]              node_valid,
  output logic [NODES-1:0]              node_first,
  output logic [NODES-1:0][WORD_W-1:0]  node_data
);

  for (genvar k = 0; k < NODES; k++) begin : g_node
    logic hit;
    assign hit           = run && (node_sel == NODE_W'(k));
    assign node_valid[k] = hit;
    assign node_first[k] = hit && first;
    assign node_data[k]  = hit ? word : '0;

    // R7: an unselected node is silent
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !node_valid[k] |-> (node_data[k] == '0) && !node_first[k]);
  end

  // R7: never more than one node driven
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(node_valid));

endmodule

// File: rtl/tmx_event_distributor.sv
module tmx_event_distributor
  import tmx_pkg::*;
#(
  parameter int SPAN    = 4,
  parameter int NODES   = 5,
  parameter int LANES   = 4,
  parameter int TOWER_W = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     in_valid,
  input  logic                                     in_start,
  input  logic [tmx_pkg::idx_bits(SPAN)-1:0]       in_slot,
  input  logic [LANES*TOWER_W-1:0]                 in_word,
  output logic [NODES-1:0]                         node_valid,
  output logic [NODES-1:0]                         node_first,
  output logic [NODES-1:0][LANES*TOWER_W-1:0]      node_data
);

  localparam int SLOT_W = idx_bits(SPAN);
  localparam int NODE_W = idx_bits(NODES);
  localparam int WORD_W = LANES * TOWER_W;

  // R11: enough nodes for a node to be free when its turn returns
  initial begin
    a_r11_nodes_cover: assert (NODES >= SPAN && SPAN >= 2)
      else $error("NODES (%0d) must be >= SPAN (%0d) and SPAN >= 2", NODES, SPAN);
  end

  logic              accept;
  logic              open_evt;
  logic              done;
  logic              run;
  logic              first;
  logic [SLOT_W-1:0] rd_slot;
  logic [NODE_W-1:0] node_sel;
  logic [WORD_W-1:0] rd_word;

  tmx_capture #(.SPAN(SPAN), .SLOT_W(SLOT_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .accept   (accept),
    .open_evt (open_evt),
    .done     (done)
  );

  tmx_bank_store #(.SPAN(SPAN), .WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_open (open_evt),
    .wr_slot (in_slot),
    .wr_word (in_word),
    .swap    (done),
    .rd_slot (rd_slot),
    .rd_word (rd_word)
  );

  tmx_replay #(.SPAN(SPAN), .NODES(NODES), .SLOT_W(SLOT_W), .NODE_W(NODE_W)) u_replay (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (done),
    .run      (run),
    .first    (first),
    .rd_slot  (rd_slot),
    .node_sel (node_sel)
  );

  tmx_fanout #(.NODES(NODES), .WORD_W(WORD_W), .NODE_W(NODE_W)) u_fanout (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .first      (first),
    .node_sel   (node_sel),
    .word       (rd_word),
    .node_valid (node_valid),
    .node_first (node_first),
    .node_data  (node_data)
  );

  // R3: replay begins the cycle after an event completes
  a_r3_start_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($countones(node_valid) == 1) && ($countones(node_first) == 1));

endmodule

// File: tb/tmx_event_distributor_test.sv
module tmx_event_distributor_test;

  localparam int N     = 4;
  localparam int K     = 5;
  localparam int LANES = 4;
  localparam int TW    = 8;
  localparam int WW    = LANES * TW;
  localparam int SW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                     in_valid = 1'b0;
  logic                     in_start = 1'b0;
  logic [SW-1:0]            in_slot = '0;
  logic [WW-1:0]            in_word = '0;
  logic [K-1:0]             node_valid;
  logic [K-1:0]             node_first;
  logic [K-1:0][WW-1:0]     node_data;

  tmx_event_distributor #(.SPAN(N), .NODES(K), .LANES(LANES), .TOWER_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_slot(in_slot), .in_word(in_word),
    .node_valid(node_valid), .node_first(node_first), .node_data(node_data)
  );

  typedef struct {
    int            cyc;
    int            node;
    bit            first;
    logic [WW-1:0] data;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit timed_out = 1'b0;

  // requirement-level model state
  int            n_evt = 0;
  bit            coll = 1'b0;
  int            wcnt = 0;
  logic [WW-1:0] m_word [N];
  bit            m_set [N];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [WW-1:0] mk(input int e, input int s);
    logic [WW-1:0] w;
    for (int l = 0; l < LANES; l++) w[l*TW +: TW] = TW'(e * 32 + s * 8 + l + 1);
    return w;
  endfunction

  // Driver: drives one crossing and pushes the expected replay on completion.
  task automatic put(input bit v, input bit s, input int slot,
                     input logic [WW-1:0] w, input string tag);
    @(negedge clk);
    in_valid = v;
    in_start = s;
    in_slot  = slot[SW-1:0];
    in_word  = w;
    if (v && (s || coll)) begin
      if (s) begin
        coll = 1'b1;
        wcnt = 0;
        for (int i = 0; i < N; i++) m_set[i] = 1'b0;
      end
      m_word[slot] = w;
      m_set[slot]  = 1'b1;
      wcnt++;
      if (wcnt == N) begin
        coll = 1'b0;
        for (int i = 0; i < N; i++) begin
          exp_t x;
          x.cyc   = cyc + 1 + i;
          x.node  = n_evt % K;
          x.first = (i == 0);
          x.data  = m_set[i] ? m_word[i] : '0;
          x.tag   = tag;
          q.push_back(x);
        end
        n_evt++;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 1'b0, 0, '0, "");
  endtask

  // Monitor: compares each produced word against the scoreboard.
  int hits;
  int hk;
  exp_t e;
  always @(negedge clk) begin
    if (mon_on) begin
      hits = $countones(node_valid);
      hk = -1;
      chk(hits <= 1, "R7", "valid count", hits, 1);
      for (int k = 0; k < K; k++) begin
        if (node_valid[k]) hk = k;
        else chk(node_data[k] == '0 && !node_first[k], "R7", "idle node quiet",
                 longint'(node_data[k]), 0);
      end
      if (hk >= 0) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected output on node", hk, -1);
        end else begin
          e = q.pop_front();
          chk(hk == e.node, "R6", "node", hk, e.node);
          chk(cyc == e.cyc, "R10", "replay cycle", cyc, e.cyc);
          chk(node_first[hk] == e.first, "R3", "first flag", node_first[hk], e.first);
          chk(node_data[hk] == e.data, e.tag, "R4 data", longint'(node_data[hk]), longint'(e.data));
        end
      end else if (q.size() > 0 && q[0].cyc <= cyc) begin
        e = q.pop_front();
        chk(1'b0, "R3", "missing word, due cycle", cyc, e.cyc);
      end
    end
  end

  task automatic run_all();
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(node_valid == '0 && node_first == '0 && node_data == '0, "R1", "outputs in reset",
        longint'(node_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(node_valid == '0 && node_first == '0 && node_data == '0, "R1", "outputs after reset",
        longint'(node_valid), 0);
    mon_on = 1'b1;
    idle(3);

    // R2 R4: in-order event, goes to node 0 (R6)
    put(1, 1, 0, mk(1, 0), "R4");
    for (int s = 1; s < N; s++) put(1, 0, s, mk(1, s), "R4");
    idle(N + 2);

    // R4: reversed slot order
    put(1, 1, 3, mk(2, 3), "R4");
    for (int s = 2; s >= 0; s--) put(1, 0, s, mk(2, s), "R4");
    idle(N + 2);

    // R2: idle crossings inside an event do not count
    put(1, 1, 1, mk(3, 1), "R2");
    idle(2);
    put(1, 0, 0, mk(3, 0), "R2");
    idle(1);
    put(1, 0, 3, mk(3, 3), "R2");
    put(1, 0, 2, mk(3, 2), "R2");
    idle(N + 2);

    // R8: slot 1 missing, slot 2 written twice (later wins)
    put(1, 1, 2, mk(4, 2), "R8");
    put(1, 0, 0, mk(4, 0), "R8");
    put(1, 0, 2, mk(4, 5), "R8");
    put(1, 0, 3, mk(4, 3), "R8");
    idle(N + 2);

    // R9: partial event dropped by a new start; stray inputs ignored
    put(1, 1, 0, mk(5, 0), "R9");
    put(1, 0, 1, mk(5, 1), "R9");
    put(1, 1, 0, mk(6, 0), "R9");
    for (int s = 1; s < N; s++) put(1, 0, s, mk(6, s), "R9");
    put(1, 0, 2, mk(7, 2), "R9");
    put(0, 1, 1, mk(7, 1), "R9");
    put(1, 0, 3, mk(7, 3), "R9");
    idle(N + 3);

    // R5: distinct lane patterns per slot
    put(1, 1, 0, 32'h11_22_33_44, "R5");
    put(1, 0, 1, 32'hA0_B0_C0_D0, "R5");
    put(1, 0, 2, 32'h0F_00_F0_FF, "R5");
    put(1, 0, 3, 32'h80_01_7E_55, "R5");
    idle(N + 2);

    // R10 R6: back-to-back events, node pointer wraps
    for (int ev = 0; ev < K + 2; ev++) begin
      put(1, 1, 0, mk(10 + ev, 0), "R10");
      for (int s = 1; s < N; s++) put(1, 0, s, mk(10 + ev, s), "R10");
    end
    idle(2 * N + 4);

    chk(q.size() == 0, "R3", "scoreboard drained", q.size(), 0);
    chk(K >= N, "R11", "nodes cover span", K, N);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) chk(1'b0, "R3", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule